// File: doc/BRIEF.md
# Dual-Side Status Flag Synchronizer

This block keeps a set of data-ready flags in step between a processor core and an external host. For each data register there are two flags. One says the host has written it and the core has not yet consumed it. The other says the core has written it and the host has not yet consumed it. Set and clear events arrive as one-cycle pulses in the core clock domain, each with a register index. The flags live in a single bank clocked by the core clock.

The core sees the flags through a register that trails the bank by one core cycle. The host has no free-running clock. Its copy of the flags moves through two stages clocked by an access clock, which is built from the host select, read strobe and write strobe. That clock goes low only while the host is selected and strobing. A change therefore reaches the host view only after the access clock has fallen, risen and fallen again. In practice, a host that wants fresh status reads it twice and keeps the second value.

Top module: `dual_status_sync`

## Requirements
- R1: While reset is high, and after reset until the first event, both status outputs read all zeros. The access-clock stages also clear on reset.
- R2: In both status outputs, bit i (0 to NUM_REGS-1) is the host-written flag of register i, and bit NUM_REGS+i is the core-written flag of register i.
- R3: A host-write event with index k sets bit k.
- R4: A core-read event with index k clears bit k. If a host-write event for the same k occurs in the same cycle, the set wins.
- R5: A core-write event with index k sets bit NUM_REGS+k.
- R6: A host-read event with index k clears bit NUM_REGS+k. If a core-write event for the same k occurs in the same cycle, the set wins.
- R7: An event sampled on core edge t appears on core_status_o after edge t+1, and not after edge t.
- R8: The access clock equals host_sel_n OR (host_rd_n AND host_wr_n). It is low only when select is low and either strobe is low, so both read and write accesses clock the host view.
- R9: A change reaches host_status_o only at the second falling edge of the access clock after the change. Of two host accesses made after a change, the first returns the previous status and the second returns the current one.
- R10: A read or write strobe made while host_sel_n is high does not clock the host view.
- R11: An event whose index is NUM_REGS or larger changes no flag.
- R12: In a cycle with no event, the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Active-high reset: synchronous for the core side, asynchronous for the access-clock stages |
| host_sel_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| hw_valid | input | 1 | Host wrote a data register (core domain pulse) |
| hw_idx | input | IW | Index of the register the host wrote |
| hr_valid | input | 1 | Host read a data register (core domain pulse) |
| hr_idx | input | IW | Index of the register the host read |
| cw_valid | input | 1 | Core wrote a data register |
| cw_idx | input | IW | Index of the register the core wrote |
| cr_valid | input | 1 | Core read a data register |
| cr_idx | input | IW | Index of the register the core read |
| core_status_o | output | 2*NUM_REGS | Status as the core sees it |
| host_status_o | output | 2*NUM_REGS | Status as the host sees it |

## Verification
The bench builds the block with its default NUM_REGS of 6. The index fields are then 3 bits wide, so the indices 6 and 7 can be driven; they exercise the rule that out-of-range events are ignored alongside the legal ones. Twelve status bits also leave room for set and clear collisions on one register while the other registers stay busy. Host accesses are mixed with bursts of events. They include write strobes and strobes made without select, so the two-stage lag of the host view is exercised against every kind of access.

// File: rtl/dss_pkg.sv
package dss_pkg;
  // width of a register index for n data registers
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dss_evt_dec.sv
module dss_evt_dec #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic          valid,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  hit
);
  // one comparator per register; indices >= N match nothing
  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = valid && (idx == IW'(g));
  end
endmodule

// File: rtl/dss_flag_bank.sv
module dss_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  // set has priority over clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= set_vec | (flags & ~clr_vec);
  end
endmodule

// File: rtl/dss_core_view.sv
module dss_core_view #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/dss_host_view.sv
module dss_host_view #(
  parameter int W = 12
) (
  input  logic         acc_clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  // the access clock stops between host accesses, so reset is asynchronous
  always_ff @(negedge acc_clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dual_status_sync.sv
module dual_status_sync #(
  parameter  int NUM_REGS = 6,
  localparam int IW       = dss_pkg::idx_width(NUM_REGS),
  localparam int SW       = 2 * NUM_REGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          hw_valid,
  input  logic [IW-1:0] hw_idx,
  input  logic          hr_valid,
  input  logic [IW-1:0] hr_idx,
  input  logic          cw_valid,
  input  logic [IW-1:0] cw_idx,
  input  logic          cr_valid,
  input  logic [IW-1:0] cr_idx,
  output logic [SW-1:0] core_status_o,
  output logic [SW-1:0] host_status_o
);
  logic [NUM_REGS-1:0] hw_hit, hr_hit, cw_hit, cr_hit;
  logic [NUM_REGS-1:0] h2c_flags, c2h_flags;
  logic [SW-1:0]       flags;
  logic                acc_clk;

  // low only while selected and strobing
  assign acc_clk = host_sel_n | (host_rd_n & host_wr_n);

  dss_evt_dec #(.N(NUM_REGS), .IW(IW)) u_dec_hw (.valid(hw_valid), .idx(hw_idx), .hit(hw_hit));
  dss_evt_dec #(.N(NUM_REGS), .IW(IW)) u_dec_hr (.valid(hr_valid), .idx(hr_idx), .hit(hr_hit));
  dss_evt_dec #(.N(NUM_REGS), .IW(IW)) u_dec_cw (.valid(cw_valid), .idx(cw_idx), .hit(cw_hit));
  dss_evt_dec #(.N(NUM_REGS), .IW(IW)) u_dec_cr (.valid(cr_valid), .idx(cr_idx), .hit(cr_hit));

  // host-written, awaiting the core
  dss_flag_bank #(.N(NUM_REGS)) u_h2c (
    .clk(clk), .rst(rst), .set_vec(hw_hit), .clr_vec(cr_hit), .flags(h2c_flags));

  // core-written, awaiting the host
  dss_flag_bank #(.N(NUM_REGS)) u_c2h (
    .clk(clk), .rst(rst), .set_vec(cw_hit), .clr_vec(hr_hit), .flags(c2h_flags));

  assign flags = {c2h_flags, h2c_flags};

  dss_core_view #(.W(SW)) u_core_view (
    .clk(clk), .rst(rst), .d(flags), .q(core_status_o));

  dss_host_view #(.W(SW)) u_host_view (
    .acc_clk(acc_clk), .rst(rst), .d(flags), .q(host_status_o));
endmodule

// File: rtl/dss_status_sync_chk.sv
module dss_status_sync_chk #(
  parameter  int NUM_REGS = 6,
  localparam int IW       = dss_pkg::idx_width(NUM_REGS),
  localparam int SW       = 2 * NUM_REGS
) (
  input logic          clk,
  input logic          rst,
  input logic          hw_valid,
  input logic [IW-1:0] hw_idx,
  input logic          hr_valid,
  input logic [IW-1:0] hr_idx,
  input logic          cw_valid,
  input logic [IW-1:0] cw_idx,
  input logic          cr_valid,
  input logic [IW-1:0] cr_idx,
  input logic [SW-1:0] flags
);
  // R3: a legal host write sets its flag
  a_r3_host_write_sets: assert property (@(posedge clk) disable iff (rst)
    (hw_valid && int'(hw_idx) < NUM_REGS) |=> flags[$past(hw_idx)]);

  // R4: a core read clears unless a same-index host write collides
  a_r4_core_read_clears: assert property (@(posedge clk) disable iff (rst)
    (cr_valid && int'(cr_idx) < NUM_REGS && !(hw_valid && hw_idx == cr_idx))
      |=> !flags[$past(cr_idx)]);

  // R5: a legal core write sets its flag in the upper half
  a_r5_core_write_sets: assert property (@(posedge clk) disable iff (rst)
    (cw_valid && int'(cw_idx) < NUM_REGS) |=> flags[NUM_REGS + int'($past(cw_idx))]);

  // R6: a host read clears unless a same-index core write collides
  a_r6_host_read_clears: assert property (@(posedge clk) disable iff (rst)
    (hr_valid && int'(hr_idx) < NUM_REGS && !(cw_valid && cw_idx == hr_idx))
      |=> !flags[NUM_REGS + int'($past(hr_idx))]);

  // R12: no event, no change
  a_r12_quiet_stable: assert property (@(posedge clk) disable iff (rst)
    (!hw_valid && !hr_valid && !cw_valid && !cr_valid) |=> $stable(flags));
endmodule

bind dual_status_sync dss_status_sync_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst),
  .hw_valid(hw_valid), .hw_idx(hw_idx),
  .hr_valid(hr_valid), .hr_idx(hr_idx),
  .cw_valid(cw_valid), .cw_idx(cw_idx),
  .cr_valid(cr_valid), .cr_idx(cr_idx),
  .flags(flags));

// File: tb/dual_status_sync_bench.sv
module dual_status_sync_bench;
  localparam int N  = 6;
  localparam int IW = 3;
  localparam int W  = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_sel_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic hw_valid = 1'b0, hr_valid = 1'b0, cw_valid = 1'b0, cr_valid = 1'b0;
  logic [IW-1:0] hw_idx = '0, hr_idx = '0, cw_idx = '0, cr_idx = '0;
  logic [W-1:0] core_status_o, host_status_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [W-1:0] exp_m = '0, exp_core = '0, exp_s1 = '0, exp_s2 = '0;

  always #4 clk = ~clk;

  dual_status_sync #(.NUM_REGS(N)) u_dual_status_sync (.*);

  function automatic logic [W-1:0] nxt(
    input logic [W-1:0] m,
    input logic hwv, input logic [IW-1:0] hwi,
    input logic hrv, input logic [IW-1:0] hri,
    input logic cwv, input logic [IW-1:0] cwi,
    input logic crv, input logic [IW-1:0] cri);
    logic [W-1:0] r = m;
    if (crv && int'(cri) < N) r[cri] = 1'b0;
    if (hrv && int'(hri) < N) r[N + int'(hri)] = 1'b0;
    if (hwv && int'(hwi) < N) r[hwi] = 1'b1;
    if (cwv && int'(cwi) < N) r[N + int'(cwi)] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive events at a negedge, pass one edge, check core view at next negedge
  task automatic step(input logic hwv, input logic [IW-1:0] hwi,
                      input logic hrv, input logic [IW-1:0] hri,
                      input logic cwv, input logic [IW-1:0] cwi,
                      input logic crv, input logic [IW-1:0] cri,
                      input string req);
    hw_valid = hwv; hw_idx = hwi; hr_valid = hrv; hr_idx = hri;
    cw_valid = cwv; cw_idx = cwi; cr_valid = crv; cr_idx = cri;
    @(posedge clk);
    exp_core = exp_m;
    exp_m = nxt(exp_m, hwv, hwi, hrv, hri, cwv, cwi, crv, cri);
    @(negedge clk);
    hw_valid = 1'b0; hr_valid = 1'b0; cw_valid = 1'b0; cr_valid = 1'b0;
    chk(req, core_status_o, exp_core);
  endtask

  task automatic idle(input string req);
    step(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, req);
  endtask

  // one host access; returns the value seen while the strobe is low
  task automatic host_access(input logic use_wr, input logic desel,
                             input string req, output logic [W-1:0] seen);
    #1;
    host_sel_n = desel;
    #1;
    if (use_wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
    if (!desel) begin
      exp_s2 = exp_s1;
      exp_s1 = exp_m;
    end
    #2;
    seen = host_status_o;
    chk(req, seen, exp_s2);
    #8;
    host_rd_n = 1'b1; host_wr_n = 1'b1;
    #1;
    host_sel_n = 1'b1;
    @(negedge clk);
    exp_core = exp_m;
  endtask

  initial begin : watchdog
    #(8 * 190000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic [W-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset core", core_status_o, '0);
    chk("R1 reset host", host_status_o, '0);
    rst = 1'b0;
    idle("R1 after reset");

    // R3/R7: set bit 2, not visible after first edge, visible after second
    step(1'b1, 3'd2, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R7 not yet");
    chk("R7 still zero", core_status_o, 12'h000);
    idle("R3");
    chk("R3 R2 bit 2", core_status_o, 12'h004);

    // R5: core write reg 4 -> bit 10
    step(1'b0, '0, 1'b0, '0, 1'b1, 3'd4, 1'b0, '0, "R5");
    idle("R5");
    chk("R5 R2 bit 10", core_status_o, 12'h404);

    // R4: collision on reg 1 (set wins), then clear reg 2
    step(1'b1, 3'd1, 1'b0, '0, 1'b0, '0, 1'b1, 3'd1, "R4 collide");
    step(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 3'd2, "R4 clear");
    idle("R4");
    chk("R4 result", core_status_o, 12'h402);

    // R6: host read reg 4 with core write reg 0 elsewhere, then collision on 0
    step(1'b0, '0, 1'b1, 3'd4, 1'b1, 3'd0, 1'b0, '0, "R6 clear");
    step(1'b0, '0, 1'b1, 3'd0, 1'b1, 3'd0, 1'b0, '0, "R6 collide");
    idle("R6");
    chk("R6 result", core_status_o, 12'h042);

    // R11: out-of-range indices 6 and 7 do nothing
    step(1'b1, 3'd6, 1'b1, 3'd7, 1'b1, 3'd7, 1'b1, 3'd6, "R11");
    idle("R11");
    chk("R11 unchanged", core_status_o, 12'h042);

    // R9: first access stale, second current
    host_access(1'b0, 1'b0, "R9 first", v);
    chk("R9 first read old", v, 12'h000);
    host_access(1'b0, 1'b0, "R9 second", v);
    chk("R9 second read new", v, 12'h042);

    // R10: deselected strobe does not clock the host view
    step(1'b1, 3'd5, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R10 prep");
    idle("R10 prep");
    host_access(1'b0, 1'b1, "R10 desel", v);
    host_access(1'b0, 1'b0, "R10 next", v);
    chk("R10 still old", v, 12'h042);

    // R8: write strobes also clock the host view
    host_access(1'b1, 1'b0, "R8 write access", v);
    chk("R8 write strobe clocks", v, 12'h062);

    // R12 and the rest: random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 10);
      if (r < 2) begin
        host_access(1'($urandom % 2), 1'($urandom % 8 == 0), "R9 R10 random", v);
      end else if (r < 4) begin
        idle("R12 random");
      end else begin
        step(1'($urandom % 3 == 0), IW'($urandom % 8),
             1'($urandom % 3 == 0), IW'($urandom % 8),
             1'($urandom % 3 == 0), IW'($urandom % 8),
             1'($urandom % 3 == 0), IW'($urandom % 8), "R3 R4 R5 R6 R11 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule